// File: doc/BRIEF.md
# Mailbox Doorbell Console Endpoint

This block is the local end of a character console that runs across a bridge between two processors. Each direction has one 32-bit mailbox and one doorbell. The far side reaches all of them through a small register bus. Outgoing characters come in on a byte stream with a ready signal. The endpoint places each character in its transmit mailbox with the top bit set, and it rings the outgoing doorbell with the console-data code. After a line feed it sends a carriage return on its own accord.

Incoming doorbell codes are acted on one cycle after they are written, and each code is then acknowledged by clearing the doorbell. The codes are: a ping, which gets a ping reply; a connect, which empties the receive ring and marks the link up; and a data notice, which moves the low byte of the receive mailbox into a circular ring. The ring drains through a valid/ready byte stream.

Flow control comes from mailbox occupancy. A mailbox that is not zero is busy. The endpoint zeroes the receive mailbox after a store only while the ring still has headroom. When the ring is nearly full, the endpoint holds the mailbox until reads have drained the ring back below the threshold.

Top module: `mbox_console`

## Requirements
- R1: After reset, every bus-readable register reads zero, the link is down, `tx_ready` is low and `rx_valid` is low.
- R2: Doorbell code 2 (connect) discards every buffered received byte, clears the full flag, zeroes the receive mailbox and sets the link bit. The link bit is status word (address 4) bit 0.
- R3: Doorbell code 1 (ping) makes the outgoing doorbell (address 3) read 1.
- R4: `tx_ready` is high only while the link is up, the transmit mailbox (address 1) is zero, and no doorbell, disconnect or carriage return is pending. An accepted byte c makes the transmit mailbox read 0x80000000|c and the outgoing doorbell read 5.
- R5: After a byte 0x0A is accepted, `tx_ready` stays low. Once the far side zeroes the transmit mailbox, the endpoint writes 0x8000000D to it on the next cycle and rings code 5 again.
- R6: Doorbell code 5 (data) stores bits 7:0 of the receive mailbox (address 0) in a DEPTH-entry ring. The stored bytes leave on `rx_data` in arrival order, with the ring pointers wrapping around. Each byte is held while `rx_ready` is low.
- R7: After a store, the endpoint zeroes the receive mailbox if occupancy is at most DEPTH-MARGIN. Otherwise it leaves the mailbox unchanged and sets the full flag, which is status bit 1.
- R8: A read that brings occupancy below DEPTH-MARGIN while the full flag is set clears the flag and zeroes the receive mailbox.
- R9: The incoming doorbell (address 2) reads zero once its code has been handled. Writing all ones to it clears it and triggers no action.
- R10: A doorbell code other than 1, 2 or 5 changes nothing except the unknown-code register (address 5), which then holds that code.
- R11: A `disc_req` pulse writes code 3 to the outgoing doorbell and takes the link down. `tx_ready` then stays low until a new connect arrives.
- R12: A data notice that arrives while the ring holds DEPTH bytes is dropped. The ring contents and the receive mailbox are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Far-side register write strobe |
| bus_addr | input | 3 | Register address (0 rx mailbox, 1 tx mailbox, 2 doorbell in, 3 doorbell out, 4 status, 5 unknown code) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, one cycle after the address |
| tx_valid | input | 1 | Outgoing byte valid |
| tx_data | input | 8 | Outgoing byte |
| tx_ready | output | 1 | Endpoint accepts an outgoing byte |
| rx_valid | output | 1 | Received byte available |
| rx_data | output | 8 | Received byte |
| rx_ready | input | 1 | Consumer takes the received byte |
| disc_req | input | 1 | Send disconnect and drop the link |

## Verification
A doorbell written at edge N is handled at edge N+1. For a data notice, the byte then shows on `rx_valid` one edge later. Bus reads return, one edge after the address is set, the value the register held before that edge. Each bench task therefore waits out the handling edge before it issues the read that checks the result. A carriage return goes out on the edge after the transmit mailbox is zeroed, so the bench waits one extra cycle before reading the mailbox. Full-flag set and release take effect on the same edge as the store or read that causes them, and the bench reads the status word straight afterwards.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  localparam int WORD_W = 32;
  localparam int CHAR_W = 8;

  localparam logic [2:0] ADR_RXMB  = 3'd0;
  localparam logic [2:0] ADR_TXMB  = 3'd1;
  localparam logic [2:0] ADR_DBIN  = 3'd2;
  localparam logic [2:0] ADR_DBOUT = 3'd3;
  localparam logic [2:0] ADR_STAT  = 3'd4;
  localparam logic [2:0] ADR_UNK   = 3'd5;

  localparam logic [WORD_W-1:0] MSG_PING = 32'd1;
  localparam logic [WORD_W-1:0] MSG_CONN = 32'd2;
  localparam logic [WORD_W-1:0] MSG_DISC = 32'd3;
  localparam logic [WORD_W-1:0] MSG_DATA = 32'd5;
  localparam logic [WORD_W-1:0] ACK_ALL  = '1;

  localparam logic [CHAR_W-1:0] CH_LF = 8'h0A;
  localparam logic [CHAR_W-1:0] CH_CR = 8'h0D;
endpackage

// File: rtl/mbc_rx_ring.sv
module mbc_rx_ring #(
  parameter int DEPTH  = 256,
  parameter int MARGIN = 4,
  parameter int DW     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         st_en,
  input  logic [DW-1:0]                st_byte,
  output logic                         rx_valid,
  output logic [DW-1:0]                rx_data,
  input  logic                         rx_ready,
  output logic [$clog2(DEPTH):0]       occ,
  output logic                         full,
  output logic                         mb_release
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = AW + 1;
  localparam int THR = DEPTH - MARGIN;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] mem_cnt, occ_nx;
  logic          pop, accept, load, full_nx, rel;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pop    = rx_valid && rx_ready;
  assign accept = st_en && (occ < CW'(DEPTH));
  assign load   = (mem_cnt != '0) && (!rx_valid || pop);
  assign occ_nx = occ + CW'(accept) - CW'(pop);

  always_comb begin
    full_nx = full;
    rel     = 1'b0;
    if (accept) begin
      if (occ_nx > CW'(THR)) full_nx = 1'b1;
      else                   rel     = 1'b1;
    end
    if (pop && full_nx && (occ_nx < CW'(THR))) begin
      full_nx = 1'b0;
      rel     = 1'b1;
    end
  end

  assign mb_release = rel && !flush;

  always_ff @(posedge clk) begin
    if (accept && !flush) mem[wr_ptr] <= st_byte;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      mem_cnt  <= '0;
      occ      <= '0;
      full     <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      occ     <= occ_nx;
      full    <= full_nx;
      mem_cnt <= mem_cnt + CW'(accept) - CW'(load);
      if (accept) wr_ptr <= bump(wr_ptr);
      if (load) begin
        rx_data  <= mem[rd_ptr];
        rd_ptr   <= bump(rd_ptr);
        rx_valid <= 1'b1;
      end else if (pop) begin
        rx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mbc_tx_path.sv
module mbc_tx_path
  import mbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              linked,
  input  logic              mb_empty,
  input  logic              hold,
  input  logic              tx_valid,
  input  logic [CHAR_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              put_en,
  output logic [CHAR_W-1:0] put_char
);
  logic cr_pend, take, cr_go;

  assign tx_ready = linked && mb_empty && !cr_pend && !hold;
  assign take     = tx_valid && tx_ready;
  assign cr_go    = cr_pend && mb_empty && !hold;
  assign put_en   = take || cr_go;
  assign put_char = cr_go ? CH_CR : tx_data;

  always_ff @(posedge clk) begin
    if (rst)                          cr_pend <= 1'b0;
    else if (cr_go)                   cr_pend <= 1'b0;
    else if (take && tx_data == CH_LF) cr_pend <= 1'b1;
  end
endmodule

// File: rtl/mbox_console.sv
module mbox_console
  import mbc_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int MARGIN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              tx_valid,
  input  logic [CHAR_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [CHAR_W-1:0] rx_data,
  input  logic              rx_ready,
  input  logic              disc_req
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [WORD_W-1:0] rx_mb, tx_mb, db_in, db_out, unk_code, rd_word;
  logic              linked, ring_full, ring_rel, put_en, hold;
  logic              db_live, is_ping, is_conn, is_data, is_unk;
  logic [CHAR_W-1:0] put_char;
  logic [CW-1:0]     rx_occ;

  assign db_live = (db_in != '0);
  assign is_ping = db_live && (db_in == MSG_PING);
  assign is_conn = db_live && (db_in == MSG_CONN);
  assign is_data = db_live && (db_in == MSG_DATA);
  assign is_unk  = db_live && !is_ping && !is_conn && !is_data;
  assign hold    = db_live || disc_req;

  mbc_rx_ring #(.DEPTH(DEPTH), .MARGIN(MARGIN), .DW(CHAR_W)) u_ring (
    .clk(clk), .rst(rst), .flush(is_conn), .st_en(is_data),
    .st_byte(rx_mb[CHAR_W-1:0]), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .occ(rx_occ), .full(ring_full), .mb_release(ring_rel)
  );

  mbc_tx_path u_tx (
    .clk(clk), .rst(rst), .linked(linked), .mb_empty(tx_mb == '0),
    .hold(hold), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .put_en(put_en), .put_char(put_char)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_mb    <= '0;
      tx_mb    <= '0;
      db_in    <= '0;
      db_out   <= '0;
      unk_code <= '0;
      linked   <= 1'b0;
    end else begin
      // handle and acknowledge the pending doorbell
      if (db_live) db_in <= '0;
      if (is_conn) linked <= 1'b1;
      if (is_unk)  unk_code <= db_in;
      if (is_conn || ring_rel) rx_mb <= '0;
      // far-side writes
      if (bus_we) begin
        case (bus_addr)
          ADR_RXMB:  rx_mb  <= bus_wdata;
          ADR_TXMB:  tx_mb  <= bus_wdata;
          ADR_DBIN:  db_in  <= (bus_wdata == ACK_ALL) ? '0 : bus_wdata;
          ADR_DBOUT: db_out <= bus_wdata;
          default: ;
        endcase
      end
      // endpoint writes take priority on the outgoing side
      if (is_ping) db_out <= MSG_PING;
      if (put_en) begin
        tx_mb  <= {1'b1, {(WORD_W-CHAR_W-1){1'b0}}, put_char};
        db_out <= MSG_DATA;
      end
      if (disc_req) begin
        linked <= 1'b0;
        db_out <= MSG_DISC;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      ADR_RXMB:  rd_word = rx_mb;
      ADR_TXMB:  rd_word = tx_mb;
      ADR_DBIN:  rd_word = db_in;
      ADR_DBOUT: rd_word = db_out;
      ADR_STAT:  rd_word = {{(WORD_W-2){1'b0}}, ring_full, linked};
      ADR_UNK:   rd_word = unk_code;
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_word;
  end
endmodule

// File: rtl/mbc_checker.sv
module mbc_checker
  import mbc_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int MARGIN = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    tx_ready,
  input logic                    linked,
  input logic [WORD_W-1:0]       tx_mb,
  input logic [WORD_W-1:0]       db_in,
  input logic [WORD_W-1:0]       db_out,
  input logic                    bus_we,
  input logic [2:0]              bus_addr,
  input logic                    disc_req,
  input logic [$clog2(DEPTH):0]  rx_occ,
  input logic                    ring_full,
  input logic                    rx_valid,
  input logic                    rx_ready,
  input logic [CHAR_W-1:0]       rx_data,
  input logic                    is_conn
);
  localparam int THR = DEPTH - MARGIN;

  AST_TX_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (tx_mb != '0) |-> tx_mb[WORD_W-1]); // R4
  AST_READY_LINKED: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> linked); // R11
  AST_FULL_LEVEL: assert property (@(posedge clk) disable iff (rst)
    ring_full |-> (rx_occ >= THR)); // R7
  AST_DB_ACKED: assert property (@(posedge clk) disable iff (rst)
    ((db_in != '0) && !(bus_we && bus_addr == ADR_DBIN)) |=> (db_in == '0)); // R9
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
    rx_occ <= DEPTH); // R12
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready && !is_conn) |=> (rx_valid && $stable(rx_data))); // R6
  AST_DISC_EFFECT: assert property (@(posedge clk) disable iff (rst)
    disc_req |=> (!linked && db_out == MSG_DISC)); // R11
  AST_CONN_FLUSH: assert property (@(posedge clk) disable iff (rst)
    is_conn |=> (!rx_valid && rx_occ == '0 && !ring_full && linked)); // R2
endmodule

bind mbox_console mbc_checker #(.DEPTH(DEPTH), .MARGIN(MARGIN)) u_chk (.*);

// File: tb/mbox_console_test.sv
module mbox_console_test;
  localparam int D = 16;
  localparam int M = 4;
  localparam int T = D - M;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_ready;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        rx_ready = 1'b0;
  logic        disc_req = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  mbox_console #(.DEPTH(D), .MARGIN(M)) uut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a;
    @(posedge clk); @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic ring(input logic [31:0] code);
    bus_wr(3'd2, code);
    @(negedge clk);
  endtask

  task automatic send_rx(input logic [31:0] word);
    bus_wr(3'd0, word);
    ring(32'd5);
  endtask

  task automatic pop_one(input logic [7:0] exp, input string tag);
    for (int w = 0; w < 8 && !rx_valid; w++) @(negedge clk);
    chk({tag, " rx_valid"}, {31'b0, rx_valid}, 32'd1);
    chk({tag, " rx_data"}, {24'b0, rx_data}, {24'b0, exp});
    rx_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    rx_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v, mb_model, last;
    logic [7:0]  q [D];
    int m, head, tail;
    logic f;

    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state
    chk("R1 tx_ready", {31'b0, tx_ready}, 0);
    chk("R1 rx_valid", {31'b0, rx_valid}, 0);
    for (int a = 0; a < 6; a++) begin
      bus_rd(3'(a), v);
      chk("R1 register", v, 0);
    end

    // R4 / R11: no transmit before link is up
    chk("R4 ready before connect", {31'b0, tx_ready}, 0);

    // R3: ping reply
    ring(32'd1);
    bus_rd(3'd3, v); chk("R3 ping reply", v, 32'd1);
    bus_rd(3'd2, v); chk("R9 doorbell acked", v, 0);

    // R2: connect sets link
    ring(32'd2);
    bus_rd(3'd4, v); chk("R2 link bit", v, 32'd1);

    // R4 / R5: sweep every byte value through the transmit path
    for (int c = 0; c < 256; c++) begin
      chk("R4 ready idle", {31'b0, tx_ready}, 1);
      tx_valid = 1'b1; tx_data = 8'(c);
      @(posedge clk); @(negedge clk);
      tx_valid = 1'b0;
      chk("R4 ready busy", {31'b0, tx_ready}, 0);
      bus_rd(3'd1, v); chk("R4 tx mailbox", v, 32'h8000_0000 | c);
      bus_rd(3'd3, v); chk("R4 out doorbell", v, 32'd5);
      bus_wr(3'd1, 32'd0);
      if (c == 10) begin
        chk("R5 ready held for CR", {31'b0, tx_ready}, 0);
        @(negedge clk);
        bus_rd(3'd1, v); chk("R5 auto CR", v, 32'h8000_000D);
        bus_rd(3'd3, v); chk("R5 CR doorbell", v, 32'd5);
        bus_wr(3'd1, 32'd0);
      end
    end

    // R6 / R7 / R12: fill the ring without reading
    m = 0; head = 0; tail = 0; f = 1'b0; mb_model = 0; last = 0;
    for (int k = 0; k < D + 1; k++) begin
      logic [7:0] b;
      logic stored;
      b = 8'(k * 7 + 3);
      last = 32'hA500 | b;
      send_rx(last);
      stored = (m < D);
      if (stored) begin
        q[tail] = b; tail = (tail + 1) % D; m++;
        if (m > T) f = 1'b1;
        mb_model = (m <= T) ? 0 : last;
      end else begin
        mb_model = last;
      end
      bus_rd(3'd0, v);
      chk(stored ? "R7 mailbox after store" : "R12 mailbox after drop", v, mb_model);
      bus_rd(3'd4, v); chk("R7 full flag", v, {30'b0, f, 1'b1});
    end

    // R8 / R6: drain and watch the release point
    for (int k = 0; k < D; k++) begin
      pop_one(q[head], "R6 ordered drain");
      head = (head + 1) % D; m--;
      if (f && m < T) begin f = 1'b0; mb_model = 0; end
      bus_rd(3'd0, v); chk("R8 mailbox on drain", v, mb_model);
      bus_rd(3'd4, v); chk("R8 full flag", v, {30'b0, f, 1'b1});
    end
    chk("R6 empty after drain", {31'b0, rx_valid}, 0);

    // R6: pointer wrap-around with interleaved reads
    for (int k = 0; k < D + 4; k++) begin
      logic [7:0] b;
      b = 8'(200 - k * 3);
      send_rx(32'h1100 | b);
      bus_rd(3'd0, v); chk("R7 mailbox cleared", v, 0);
      pop_one(b, "R6 wrap");
    end

    // R2: connect discards buffered bytes
    send_rx(32'hA511); send_rx(32'hA522); send_rx(32'hA533);
    ring(32'd2);
    chk("R2 flush rx_valid", {31'b0, rx_valid}, 0);
    bus_rd(3'd4, v); chk("R2 status after connect", v, 32'd1);
    bus_rd(3'd0, v); chk("R2 mailbox zeroed", v, 0);
    send_rx(32'hA55A);
    pop_one(8'h5A, "R2 first byte after connect");

    // R9: all-ones acknowledge does nothing else
    bus_wr(3'd0, 32'h1234);
    bus_wr(3'd2, 32'hFFFF_FFFF);
    @(negedge clk);
    bus_rd(3'd2, v); chk("R9 doorbell cleared", v, 0);
    bus_rd(3'd0, v); chk("R9 mailbox kept", v, 32'h1234);
    chk("R9 no store", {31'b0, rx_valid}, 0);
    bus_wr(3'd0, 32'd0);

    // R10: unknown code
    bus_wr(3'd3, 32'd0);
    ring(32'd7);
    bus_rd(3'd5, v); chk("R10 unknown latched", v, 32'd7);
    bus_rd(3'd3, v); chk("R10 no reply", v, 0);
    bus_rd(3'd2, v); chk("R10 acked", v, 0);
    bus_rd(3'd4, v); chk("R10 link kept", v, 32'd1);
    chk("R10 no store", {31'b0, rx_valid}, 0);

    // R11: disconnect
    chk("R11 ready before disc", {31'b0, tx_ready}, 1);
    disc_req = 1'b1;
    @(posedge clk); @(negedge clk);
    disc_req = 1'b0;
    bus_rd(3'd3, v); chk("R11 disc doorbell", v, 32'd3);
    bus_rd(3'd4, v); chk("R11 link down", v, 0);
    chk("R11 ready low", {31'b0, tx_ready}, 0);
    ring(32'd2);
    chk("R11 ready after reconnect", {31'b0, tx_ready}, 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule